// File: doc/BRIEF.md
# Bit-Stuffing Synchronous Frame Transmitter

This block turns a stream of host bytes into a bit-oriented synchronous frame on one serial line. The host places each byte into a single holding register. The block then sends a frame in this order: an opening flag, the data bytes least significant bit first, a complemented 16-bit frame check sequence, and a closing flag. A zero is stuffed after every run of five ones inside the data and check fields. Between frames the line carries either repeated flags or continuous ones, as a mode input selects.

The frame ends when the holding register is found empty at a character boundary. If the end-of-message latch is clear at that point, the block appends the check sequence and a closing flag. It also sets the latch and pulses an interrupt. While that tail is on the line, the check sequence has priority: a byte written during the tail waits in the holding register and opens the next frame. Two optional behaviours let the host stream frames back to back without issuing commands. The first clears the latch and presets the check generator at every frame start. The second emits an opening flag automatically when the line idles at ones.

Top module: `hdlc_frame_tx`

## Requirements
- R1: While reset is asserted, `tx_bit` is 1, `buf_empty` is 1 and `eom_irq` is 0. The end-of-message latch starts set. With `mark_idle` at 0 and nothing written, the line repeats the flag 0x7E, least significant bit first.
- R2: A write is taken only when `buf_empty` is 1. `buf_empty` falls the clock after an accepted write. It rises on the bit tick in which the held byte moves into the shift register. A write made while `buf_empty` is 0 is discarded.
- R3: A frame is sent as: a flag, each data byte least significant bit first, the check sequence, and a closing flag 0x7E. A flag already being sent as idle serves as the opening flag.
- R4: Inside the data and check fields, a 0 is inserted after every five consecutive 1s, including runs that cross byte boundaries. Flags and idle ones are never stuffed.
- R5: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected (shift right, constant 0x8408). It is preset to 0xFFFF at every frame start and covers only the data bits. It is sent complemented, low byte first, each byte least significant bit first. For the data "123456789" the complemented value is 0x906E.
- R6: Suppose the holding register is empty at the end of a data character. If the latch is clear, the block sends the check sequence and then a closing flag, sets the latch, and raises `eom_irq` for exactly one clock when the first check byte is loaded. If the latch is set, only a closing flag follows and no interrupt is raised.
- R7: A byte written while the check sequence or closing flag is being sent leaves both fields unchanged. The byte stays held, with `buf_empty` at 0, until the tail has left. It is then the first data byte of the next frame.
- R8: A one-clock pulse on `eom_clr` clears the end-of-message latch. Setting the latch takes precedence in the same clock.
- R9: With `auto_eom` at 1, the latch clears itself when a frame starts, so a frame ends with the check sequence without any `eom_clr`.
- R10: With `mark_idle` at 1, the idle line carries ones in whole groups of eight. A group that has begun is finished before any flag or data is loaded. The closing flag of a frame is always sent in full.
- R11: With `mark_idle` and `auto_open` both at 1, a frame starting from idle begins with an opening flag before its first data byte. With `mark_idle` at 1 and `auto_open` at 0, the first data byte follows the idle ones directly.
- R12: `tx_bit` changes only in the clock after a cycle with `bit_en` at 1, and each such tick produces one line bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One line bit is produced per cycle with this high |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| mark_idle | input | 1 | 1: idle with continuous ones, 0: idle with flags |
| auto_open | input | 1 | Send an opening flag automatically when starting a frame from mark idle |
| auto_eom | input | 1 | Clear the end-of-message latch automatically at each frame start |
| eom_clr | input | 1 | Command pulse clearing the end-of-message latch |
| tx_bit | output | 1 | Serial line bit |
| buf_empty | output | 1 | Holding register can take a byte |
| eom_irq | output | 1 | One-clock pulse when the check sequence of a frame is started |

## Verification
The embedded properties take for granted that the host writes only while `buf_empty` is 1. They also assume that `eom_clr` is a single-clock pulse. The latch-clear property is only claimed in cycles where no character is being loaded, because a load that sets the latch wins. The stimulus waits for `buf_empty` before each write, except where one deliberate extra write tests that full writes are discarded. It changes the idle and automatic modes only while the line is idle, and it drives `bit_en` both continuously and in random and held-low patterns.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   // What the shift register is currently carrying
   typedef enum logic [2:0] {
      K_IDLE_FLAG,
      K_IDLE_ONES,
      K_OPEN,
      K_DATA,
      K_FCS,
      K_CLOSE
   } char_kind_e;

endpackage

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              consume,
   output logic              hold_vld,
   output logic [CHAR_W-1:0] hold_byte
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_byte <= '0;
      end else if (consume) begin
         hold_vld <= 1'b0;
      end else if (wr_en && !hold_vld) begin
         hold_vld  <= 1'b1;
         hold_byte <= wr_data;
      end
   end

   // R2: the sequencer only takes a byte that is actually held
   a_r2_consume_valid: assert property (@(posedge clk) disable iff (!rst_n)
      consume |-> hold_vld);

   // R7: a held byte is neither lost nor overwritten until it is taken
   a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_vld && !consume) |=> (hold_vld && $stable(hold_byte)));

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
   parameter int              FCS_W      = 16,
   parameter logic [FCS_W-1:0] FCS_POLY  = 16'h8408,
   parameter logic [FCS_W-1:0] FCS_INIT  = '1,
   parameter bit              FCS_INVERT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             preset,
   input  logic             upd,
   input  logic             bit_in,
   output logic [FCS_W-1:0] fcs_tx
);

   logic [FCS_W-1:0] fcs_q;
   logic [FCS_W-1:0] base;
   logic [FCS_W-1:0] stepped;

   always_comb begin
      base    = preset ? FCS_INIT : fcs_q;
      stepped = base >> 1;
      if (base[0] ^ bit_in) stepped = stepped ^ FCS_POLY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fcs_q <= FCS_INIT;
      else if (upd)    fcs_q <= stepped;
      else if (preset) fcs_q <= FCS_INIT;
   end

   generate
      if (FCS_INVERT) begin : g_inv
         assign fcs_tx = ~fcs_q;
      end else begin : g_true
         assign fcs_tx = fcs_q;
      end
   endgenerate

   // R5: the remainder only moves on data bits or a frame-start preset
   a_r5_fcs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !preset) |=> $stable(fcs_q));

endmodule

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter #(
   parameter int CHAR_W    = 8,
   parameter int STUFF_RUN = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [CHAR_W-1:0] ld_char,
   input  logic              ld_stuff,
   input  logic              ld_data,
   output logic              char_req,
   output logic              data_upd,
   output logic              data_bit,
   output logic              tx_bit
);

   localparam int CNT_W = $clog2(CHAR_W + 1);
   localparam int RUN_W = $clog2(STUFF_RUN + 1);

   logic [CHAR_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;
   logic [RUN_W-1:0]  ones_q;
   logic              stuff_q;
   logic              data_q;
   logic              tx_q;
   logic              stuff_now;
   logic              out_bit;
   logic              out_stuffable;

   always_comb begin
      stuff_now     = (ones_q == RUN_W'(STUFF_RUN));
      char_req      = bit_en && !stuff_now && (left_q == '0);
      out_bit       = char_req ? ld_char[0] : sh_q[0];
      out_stuffable = char_req ? ld_stuff : stuff_q;
      data_upd      = bit_en && !stuff_now && (char_req ? ld_data : data_q);
      data_bit      = out_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         left_q  <= '0;
         ones_q  <= '0;
         stuff_q <= 1'b0;
         data_q  <= 1'b0;
         tx_q    <= 1'b1;
      end else if (bit_en) begin
         if (stuff_now) begin
            tx_q   <= 1'b0;
            ones_q <= '0;
         end else begin
            tx_q   <= out_bit;
            ones_q <= (out_stuffable && out_bit) ? ones_q + RUN_W'(1) : '0;
            if (char_req) begin
               sh_q    <= ld_char >> 1;
               left_q  <= CNT_W'(CHAR_W - 1);
               stuff_q <= ld_stuff;
               data_q  <= ld_data;
            end else begin
               sh_q   <= sh_q >> 1;
               left_q <= left_q - CNT_W'(1);
            end
         end
      end
   end

   assign tx_bit = tx_q;

   // R12: no tick, no line change
   a_r12_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));

   // R4: a run of stuffable ones never grows past the limit
   a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= RUN_W'(STUFF_RUN));

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
   import hdlc_tx_pkg::*;
#(
   parameter int               CHAR_W   = 8,
   parameter int               FCS_W    = 16,
   parameter logic [CHAR_W-1:0] FLAG_PAT = 8'h7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_req,
   input  logic              hold_vld,
   input  logic [CHAR_W-1:0] hold_byte,
   input  logic              mark_idle,
   input  logic              auto_open,
   input  logic              auto_eom,
   input  logic              eom_clr,
   input  logic [FCS_W-1:0]  fcs_tx,
   output logic [CHAR_W-1:0] ld_char,
   output logic              ld_stuff,
   output logic              ld_data,
   output logic              consume,
   output logic              fcs_preset,
   output logic              eom_irq
);

   localparam int FCS_BYTES = FCS_W / CHAR_W;
   localparam int IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

   char_kind_e       last_q;
   char_kind_e       nk;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] sel_idx;
   logic             eom_lat;
   logic             irq_q;
   logic             fstart;
   logic             set_eom;

   always_comb begin
      nk      = last_q;
      sel_idx = idx_q;
      ld_char = FLAG_PAT;
      consume = 1'b0;
      fstart  = 1'b0;
      set_eom = 1'b0;
      unique case (last_q)
         K_IDLE_FLAG, K_IDLE_ONES, K_CLOSE: begin
            if (hold_vld) begin
               fstart = 1'b1;
               if (mark_idle && auto_open) begin
                  nk = K_OPEN;
               end else begin
                  nk      = K_DATA;
                  ld_char = hold_byte;
                  consume = 1'b1;
               end
            end else if (mark_idle) begin
               nk      = K_IDLE_ONES;
               ld_char = '1;
            end else begin
               nk = K_IDLE_FLAG;
            end
         end
         K_OPEN, K_DATA: begin
            if (hold_vld) begin
               nk      = K_DATA;
               ld_char = hold_byte;
               consume = 1'b1;
            end else if (!eom_lat) begin
               nk      = K_FCS;
               sel_idx = '0;
               ld_char = fcs_tx[int'(sel_idx)*CHAR_W +: CHAR_W];
               set_eom = 1'b1;
            end else begin
               nk = K_CLOSE;
            end
         end
         K_FCS: begin
            if (idx_q == IDX_W'(FCS_BYTES - 1)) begin
               nk = K_CLOSE;
            end else begin
               nk      = K_FCS;
               sel_idx = idx_q + IDX_W'(1);
               ld_char = fcs_tx[int'(sel_idx)*CHAR_W +: CHAR_W];
            end
         end
         default: nk = K_IDLE_FLAG;
      endcase
      consume    = consume && char_req;
      fcs_preset = fstart && char_req;
      ld_stuff   = (nk == K_DATA) || (nk == K_FCS);
      ld_data    = (nk == K_DATA);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= K_IDLE_FLAG;
         idx_q   <= '0;
         eom_lat <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= char_req && set_eom;
         if (char_req) begin
            last_q <= nk;
            idx_q  <= sel_idx;
         end
         if (char_req && set_eom)
            eom_lat <= 1'b1;
         else if (eom_clr || (char_req && fstart && auto_eom))
            eom_lat <= 1'b0;
      end
   end

   assign eom_irq = irq_q;

   // R6: the event is a single-clock pulse
   a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eom_irq |=> !eom_irq);

   // R6: the pulse always comes with the latch set
   a_r6_irq_with_latch: assert property (@(posedge clk) disable iff (!rst_n)
      eom_irq |-> eom_lat);

   // R8: the command clears the latch when nothing is loading
   a_r8_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (eom_clr && !char_req) |=> !eom_lat);

   // R9: automatic clear at each frame start
   a_r9_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (fcs_preset && auto_eom) |=> !eom_lat);

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx #(
   parameter int CHAR_W     = 8,
   parameter int FCS_W      = 16,
   parameter int STUFF_RUN  = 5,
   parameter bit FCS_INVERT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              mark_idle,
   input  logic              auto_open,
   input  logic              auto_eom,
   input  logic              eom_clr,
   output logic              tx_bit,
   output logic              buf_empty,
   output logic              eom_irq
);

   localparam logic [CHAR_W-1:0] FLAG_PAT = CHAR_W'(8'h7E);
   localparam logic [FCS_W-1:0]  FCS_POLY = FCS_W'(16'h8408);

   generate
      if (CHAR_W != 8) begin : g_bad_char
         $error("hdlc_frame_tx: CHAR_W must be 8");
      end
      if ((FCS_W % CHAR_W) != 0 || FCS_W < CHAR_W) begin : g_bad_fcs
         $error("hdlc_frame_tx: FCS_W must be a whole number of characters");
      end
      if (STUFF_RUN < 1 || STUFF_RUN > CHAR_W - 3) begin : g_bad_run
         $error("hdlc_frame_tx: STUFF_RUN must keep the flag unique");
      end
   endgenerate

   logic              hold_vld;
   logic [CHAR_W-1:0] hold_byte;
   logic              consume;
   logic              char_req;
   logic              data_upd;
   logic              data_bit;
   logic [CHAR_W-1:0] ld_char;
   logic              ld_stuff;
   logic              ld_data;
   logic              fcs_preset;
   logic [FCS_W-1:0]  fcs_tx;

   hdlc_tx_hold #(.CHAR_W(CHAR_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .consume   (consume),
      .hold_vld  (hold_vld),
      .hold_byte (hold_byte)
   );

   hdlc_tx_fcs #(
      .FCS_W      (FCS_W),
      .FCS_POLY   (FCS_POLY),
      .FCS_INIT   ('1),
      .FCS_INVERT (FCS_INVERT)
   ) u_fcs (
      .clk    (clk),
      .rst_n  (rst_n),
      .preset (fcs_preset),
      .upd    (data_upd),
      .bit_in (data_bit),
      .fcs_tx (fcs_tx)
   );

   hdlc_tx_seq #(
      .CHAR_W   (CHAR_W),
      .FCS_W    (FCS_W),
      .FLAG_PAT (FLAG_PAT)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .char_req   (char_req),
      .hold_vld   (hold_vld),
      .hold_byte  (hold_byte),
      .mark_idle  (mark_idle),
      .auto_open  (auto_open),
      .auto_eom   (auto_eom),
      .eom_clr    (eom_clr),
      .fcs_tx     (fcs_tx),
      .ld_char    (ld_char),
      .ld_stuff   (ld_stuff),
      .ld_data    (ld_data),
      .consume    (consume),
      .fcs_preset (fcs_preset),
      .eom_irq    (eom_irq)
   );

   hdlc_tx_shifter #(
      .CHAR_W    (CHAR_W),
      .STUFF_RUN (STUFF_RUN)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .ld_char  (ld_char),
      .ld_stuff (ld_stuff),
      .ld_data  (ld_data),
      .char_req (char_req),
      .data_upd (data_upd),
      .data_bit (data_bit),
      .tx_bit   (tx_bit)
   );

   assign buf_empty = !hold_vld;

endmodule

// File: tb/sim_hdlc_frame_tx.sv
module sim_hdlc_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       mark_idle = 1'b0;
   logic       auto_open = 1'b0;
   logic       auto_eom = 1'b0;
   logic       eom_clr = 1'b0;
   logic       tick_man = 1'b1;
   logic       rand_mode = 1'b0;
   logic       rnd_q = 1'b1;
   logic       bit_en;
   logic       tx_bit;
   logic       buf_empty;
   logic       eom_irq;

   int checks = 0;
   int fails = 0;
   int irq_cnt = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;   // 250 MHz

   assign bit_en = rand_mode ? rnd_q : tick_man;
   always @(negedge clk) rnd_q <= ($urandom % 4) != 0;

   hdlc_frame_tx u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .mark_idle (mark_idle),
      .auto_open (auto_open),
      .auto_eom  (auto_eom),
      .eom_clr   (eom_clr),
      .tx_bit    (tx_bit),
      .buf_empty (buf_empty),
      .eom_irq   (eom_irq)
   );

   // ---------------- reference model: queue of pending line bits ----------------
   bit          q[$];
   bit          m_hold_vld;
   logic [7:0]  m_hold;
   bit          m_lat;
   bit          m_irq;
   bit          m_tx;
   int          m_last;     // 0 idle flag, 1 idle ones, 2 open, 3 data, 4 fcs low, 5 fcs high, 6 close
   int          m_ones;
   logic [15:0] m_crc;
   logic [15:0] m_fcs_last;

   task automatic push_plain(input logic [7:0] c);
      for (int i = 0; i < 8; i++) q.push_back(c[i]);
      m_ones = 0;
   endtask

   task automatic push_stuffed(input logic [7:0] c);
      for (int i = 0; i < 8; i++) begin
         q.push_back(c[i]);
         if (c[i]) begin
            m_ones++;
            if (m_ones == 5) begin
               q.push_back(1'b0);
               m_ones = 0;
            end
         end else begin
            m_ones = 0;
         end
      end
   endtask

   task automatic push_data(input logic [7:0] c);
      for (int i = 0; i < 8; i++) begin
         bit fb;
         fb = m_crc[0] ^ c[i];
         m_crc = m_crc >> 1;
         if (fb) m_crc = m_crc ^ 16'h8408;
      end
      push_stuffed(c);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_hold_vld = 0; m_hold = 0; m_lat = 1; m_irq = 0; m_tx = 1;
         m_last = 0; m_ones = 0; m_crc = 16'hFFFF; m_fcs_last = 0;
      end else begin
         bit old_vld, fs, set;
         old_vld = m_hold_vld; fs = 0; set = 0;
         if (bit_en) begin
            if (q.size() == 0) begin
               case (m_last)
                  0, 1, 6: begin
                     if (m_hold_vld) begin
                        fs = 1; m_crc = 16'hFFFF;
                        if (mark_idle && auto_open) begin
                           push_plain(8'h7E); m_last = 2;
                        end else begin
                           push_data(m_hold); m_hold_vld = 0; m_last = 3;
                        end
                     end else if (mark_idle) begin
                        push_plain(8'hFF); m_last = 1;
                     end else begin
                        push_plain(8'h7E); m_last = 0;
                     end
                  end
                  2, 3: begin
                     if (m_hold_vld) begin
                        push_data(m_hold); m_hold_vld = 0; m_last = 3;
                     end else if (!m_lat) begin
                        m_fcs_last = ~m_crc;
                        push_stuffed(m_fcs_last[7:0]); m_last = 4; set = 1;
                     end else begin
                        push_plain(8'h7E); m_last = 6;
                     end
                  end
                  4: begin push_stuffed(m_fcs_last[15:8]); m_last = 5; end
                  default: begin push_plain(8'h7E); m_last = 6; end
               endcase
            end
            m_tx = q.pop_front();
         end
         if (wr_en && !old_vld) begin
            m_hold_vld = 1; m_hold = wr_data;
         end
         if (set) m_lat = 1;
         else if (eom_clr || (fs && auto_eom)) m_lat = 0;
         m_irq = set;
      end
   end

   // ---------------- checking ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check(tx_bit == m_tx, cur_req, "tx_bit", tx_bit, m_tx);
         check(buf_empty == !m_hold_vld, cur_req, "buf_empty", buf_empty, !m_hold_vld);
         check(eom_irq == m_irq, cur_req, "eom_irq", eom_irq, m_irq);
         if (eom_irq) irq_cnt++;
      end
   end

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
   end

   // ---------------- stimulus helpers (all start and end at a negedge) ----------------
   task automatic send_byte(input logic [7:0] b);
      int n = 0;
      while (!buf_empty && n < 5000) begin @(negedge clk); n++; end
      wr_data = b; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (!eom_irq && n < 3000) begin @(negedge clk); n++; end
      check(eom_irq == 1'b1, req, "eom_irq seen", eom_irq, 1);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int base;
      logic [7:0] win;
      bit seen;
      bit allones;
      logic t;

      // R1 reset state
      idle(3);
      check(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
      check(buf_empty == 1'b1, "R1", "buf_empty in reset", buf_empty, 1);
      check(eom_irq == 1'b0, "R1", "eom_irq in reset", eom_irq, 0);
      rst_n = 1'b1;
      idle(40);

      // R3 / R5: frame "123456789", automatic latch clear (R9)
      cur_req = "R5"; auto_eom = 1'b1;
      for (int i = 0; i < 9; i++) send_byte(8'h31 + 8'(i));
      wait_irq("R9");
      check(m_fcs_last == 16'h906E, "R5", "check value", m_fcs_last, 16'h906E);
      idle(40);

      // R4: stuffing-heavy data, runs across byte edges
      cur_req = "R4";
      send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h3E);
      send_byte(8'h7E); send_byte(8'hFC);
      wait_irq("R4");
      idle(40);

      // R7: write during the check-sequence tail
      cur_req = "R7";
      send_byte(8'h12); send_byte(8'h9C);
      wait_irq("R6");
      wr_data = 8'hA5; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
      idle(20);
      check(buf_empty == 1'b0, "R7", "buf_empty during tail", buf_empty, 0);
      send_byte(8'h5A);
      wait_irq("R7");
      idle(40);

      // R8: manual latch clear
      cur_req = "R8"; auto_eom = 1'b0;
      base = irq_cnt;
      send_byte(8'h41);
      eom_clr = 1'b1; @(negedge clk); eom_clr = 1'b0;
      send_byte(8'h42); send_byte(8'h43);
      idle(80);
      check(irq_cnt - base == 1, "R8", "irq count with command", irq_cnt - base, 1);

      // R6: latch left set -> closing flag only, no event
      cur_req = "R6";
      base = irq_cnt;
      send_byte(8'h44); send_byte(8'h45);
      idle(80);
      check(irq_cnt - base == 0, "R6", "irq count with latch set", irq_cnt - base, 0);

      // R10: mark idle, groups of eight ones
      cur_req = "R10"; mark_idle = 1'b1; auto_eom = 1'b1;
      idle(30);
      allones = 1;
      for (int i = 0; i < 16; i++) begin
         if (!tx_bit) allones = 0;
         @(negedge clk);
      end
      check(allones, "R10", "idle ones", allones, 1);
      // R11 without automatic flag: data follows ones directly
      cur_req = "R11";
      send_byte(8'h21); send_byte(8'h22);
      wait_irq("R10");
      idle(40);

      // R11: automatic opening flag from mark idle
      auto_open = 1'b1;
      send_byte(8'h11);
      win = 8'hFF; seen = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         win = {tx_bit, win[7:1]};
         if (win == 8'h7E) seen = 1;
      end
      check(seen, "R11", "opening flag seen", seen, 1);
      send_byte(8'h22); send_byte(8'h33);
      wait_irq("R11");
      idle(40);

      // R12: held-low ticks and random tick pattern
      cur_req = "R12"; mark_idle = 1'b0; auto_open = 1'b0;
      for (int k = 0; k < 4; k++) begin
         idle(3);
         tick_man = 1'b0; t = tx_bit;
         @(negedge clk);
         check(tx_bit == t, "R12", "line held without tick", tx_bit, t);
         tick_man = 1'b1;
      end
      rand_mode = 1'b1;
      send_byte(8'hF0); send_byte(8'h0F); send_byte(8'hBE); send_byte(8'hEF);
      wait_irq("R12");
      idle(100);
      rand_mode = 1'b0;

      // R2: second write while full is discarded
      cur_req = "R2";
      idle(5);
      wr_data = 8'h66; wr_en = 1'b1; @(negedge clk);
      check(buf_empty == 1'b0, "R2", "buf_empty after write", buf_empty, 0);
      wr_data = 8'h99; @(negedge clk); wr_en = 1'b0;
      wait_irq("R2");
      idle(40);

      report();
   end

endmodule